// File: doc/BRIEF.md
# Memory-Mapped 64-bit Global Timer

This block is a 64-bit up-counter behind a 32-bit register port. While the run bit is set, it advances by one on each cycle in which the count-enable input `tick_i` is high. That input comes from a strobe at the timer rate, which is half the core clock. With a 333,333,333 Hz timer rate, one count is about 3 ns.

A 64-bit comparator raises a sticky event flag whenever the count is at or above the compare value. When auto-increment is on, each match moves the compare value forward by a programmed 32-bit step, so the block produces a periodic event. The flag drives `irq_o` only while the interrupt enable bit is set. Software clears the flag by writing a 1 to it.

Software reaches the registers through a synchronous write port and a combinational read port, both selected by a 3-bit word index (byte offset divided by four). Each 64-bit value is split across a pair of 32-bit registers. Reads of the counter halves return the live value with no latching, so software handles any carry between the halves itself.

Top module: `gtimer64`

## Requirements
- R1: Word indices 0 and 1 read the low and high halves of the 64-bit counter. The counter resets to 0. It adds 1 on each clock in which `tick_i` is high and control bit 0 is set, and it wraps from all ones to 0.
- R2: Word index 2 is the control register. Bit 0 is run, bit 1 is compare enable, bit 2 is interrupt enable and bit 3 is auto-increment. Bits 31..4 read as 0.
- R3: A write to word index 0 or 1 loads that counter half only while control bit 0 is 0. While the timer runs, such a write is ignored and counting continues.
- R4: `irq_o` is high exactly when the event flag is set and control bit 2 is set.
- R5: Word index 3, bit 0, reads the sticky event flag, and the other bits read as 0. Writing a 1 to bit 0 clears the flag and writing a 0 has no effect. If a match occurs in the same cycle as a clear write, the flag stays set.
- R6: Word indices 4 and 5 hold the low and high halves of the comparator. When compare enable is set and the counter is greater than or equal to the comparator, the flag reads as 1 after the next clock edge. A comparator already below the count therefore fires at once.
- R7: Word index 6 holds the 32-bit increment. When auto-increment is set, each matching cycle adds the zero-extended increment to the comparator. A software write to a comparator half in that same cycle takes precedence over the addition.
- R8: When auto-increment is clear, a match leaves the comparator unchanged.
- R9: All registers reset to 0, and word index 7 reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Count-enable strobe at the timer rate |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Word index of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Interrupt output: event flag gated by interrupt enable |

## Verification
The assertions assume that `tick_i`, `wr_en_i`, `addr_i` and `wdata_i` are stable and known around each rising edge. They also assume that at most one register is written per cycle, since the port carries a single address. The bench drives every input just after the falling edge and samples only at the falling edge, so each write reaches exactly one register in one cycle. Its random phase keeps the comparator step and the counter loads inside ranges where matches occur within the run.

// File: rtl/gtimer64.sv
module gtimer64 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        wr_en_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  localparam logic [2:0] A_CLO = 3'd0, A_CHI = 3'd1, A_CTL = 3'd2, A_STS = 3'd3,
                         A_KLO = 3'd4, A_KHI = 3'd5, A_INC = 3'd6;

  logic [63:0] cnt, cmp;
  logic [31:0] inc;
  logic [3:0]  ctrl;
  logic        flag;

  wire run  = ctrl[0];
  wire hit  = ctrl[1] && (cnt >= cmp);
  wire clr  = wr_en_i && addr_i == A_STS && wdata_i[0];
  wire wcmp = wr_en_i && (addr_i == A_KLO || addr_i == A_KHI);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (!run && wr_en_i && addr_i == A_CLO) cnt[31:0] <= wdata_i;
    else if (!run && wr_en_i && addr_i == A_CHI) cnt[63:32] <= wdata_i;
    else if (run && tick_i) cnt <= cnt + 64'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cmp <= '0;
    else if (wr_en_i && addr_i == A_KLO) cmp[31:0] <= wdata_i;
    else if (wr_en_i && addr_i == A_KHI) cmp[63:32] <= wdata_i;
    else if (hit && ctrl[3]) cmp <= cmp + {32'd0, inc};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl <= '0;
      inc  <= '0;
      flag <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == A_CTL) ctrl <= wdata_i[3:0];
      if (wr_en_i && addr_i == A_INC) inc <= wdata_i;
      if (hit) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      A_CLO:   rdata_o = cnt[31:0];
      A_CHI:   rdata_o = cnt[63:32];
      A_CTL:   rdata_o = {28'd0, ctrl};
      A_STS:   rdata_o = {31'd0, flag};
      A_KLO:   rdata_o = cmp[31:0];
      A_KHI:   rdata_o = cmp[63:32];
      A_INC:   rdata_o = inc;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o = flag & ctrl[2];
endmodule

// File: rtl/gtimer64_chk.sv
module gtimer64_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_i,
  input logic        wr_en_i,
  input logic [2:0]  addr_i,
  input logic [31:0] wdata_i,
  input logic [63:0] cnt,
  input logic [63:0] cmp,
  input logic [31:0] inc,
  input logic [3:0]  ctrl,
  input logic        flag,
  input logic        irq_o
);
  wire cnt_wr = wr_en_i && (addr_i == 3'd0 || addr_i == 3'd1);
  wire cmp_wr = wr_en_i && (addr_i == 3'd4 || addr_i == 3'd5);
  wire clr_wr = wr_en_i && addr_i == 3'd3 && wdata_i[0];
  wire match  = ctrl[1] && cnt >= cmp;

  a_r1_step: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl[0] && tick_i |=> cnt == $past(cnt) + 64'd1);
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[0] && !cnt_wr |=> $stable(cnt));
  a_r4_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> ctrl[2]);
  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !clr_wr |=> flag);
  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr && !match |=> !flag);
  a_r6_set: assert property (@(posedge clk) disable iff (!rst_n)
    match |=> flag);
  a_r7_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    match && ctrl[3] && !cmp_wr |=> cmp == $past(cmp) + {32'd0, $past(inc)});
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl[3] && !cmp_wr |=> $stable(cmp));
endmodule

bind gtimer64 gtimer64_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
  .addr_i(addr_i), .wdata_i(wdata_i), .cnt(cnt), .cmp(cmp), .inc(inc),
  .ctrl(ctrl), .flag(flag), .irq_o(irq_o)
);

// File: tb/gtimer64_tb_top.sv
module gtimer64_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic irq;
  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  logic [63:0] m_cnt = '0, m_cmp = '0;
  logic [31:0] m_inc = '0;
  logic [3:0]  m_ctl = '0;
  logic        m_flag = 1'b0;

  always #4 clk = ~clk;

  gtimer64 dut_i (.clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr),
                  .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq));

  always @(posedge clk) begin
    logic [63:0] c, k;
    logic hit;
    c = m_cnt; k = m_cmp;
    hit = m_ctl[1] && (m_cnt >= m_cmp);
    if (!rst_n) begin
      m_cnt = '0; m_cmp = '0; m_inc = '0; m_ctl = '0; m_flag = 0;
    end else begin
      if (m_ctl[0] && tick) c = m_cnt + 1;
      if (wr && !m_ctl[0] && addr == 0) c = {m_cnt[63:32], wdata};
      if (wr && !m_ctl[0] && addr == 1) c = {wdata, m_cnt[31:0]};
      if (hit && m_ctl[3]) k = m_cmp + {32'd0, m_inc};
      if (wr && addr == 4) k = {m_cmp[63:32], wdata};
      if (wr && addr == 5) k = {wdata, m_cmp[31:0]};
      if (wr && addr == 3 && wdata[0]) m_flag = 0;
      if (hit) m_flag = 1;
      if (wr && addr == 2) m_ctl = wdata[3:0];
      if (wr && addr == 6) m_inc = wdata;
      m_cnt = c; m_cmp = k;
    end
  end

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      0: return m_cnt[31:0];
      1: return m_cnt[63:32];
      2: return {28'd0, m_ctl};
      3: return {31'd0, m_flag};
      4: return m_cmp[31:0];
      5: return m_cmp[63:32];
      6: return m_inc;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag(input logic [2:0] a);
    case (a)
      0, 1: return "R1";
      2: return "R2";
      3: return "R5";
      4, 5: return "R6";
      6: return "R7";
      default: return "R9";
    endcase
  endfunction

  // every falling edge: compare read data and interrupt against the model
  always @(negedge clk) if (rst_n && !done) begin
    checks += 2;
    if (rdata !== m_read(addr)) begin
      errors++;
      $display("FAIL %s addr %0d actual %h expected %h", tag(addr), addr, rdata, m_read(addr));
    end
    if (irq !== (m_flag & m_ctl[2])) begin
      errors++;
      $display("FAIL R4 irq actual %b expected %b", irq, m_flag & m_ctl[2]);
    end
  end

  task automatic put(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); #1; wr = 1; addr = a; wdata = d;
    @(negedge clk); #1; wr = 0;
  endtask

  task automatic run(input int n, input bit rnd_tick);
    repeat (n) begin
      @(negedge clk); #1;
      addr = 3'($urandom_range(0, 7));
      tick = rnd_tick ? 1'($urandom) : 1'b1;
    end
  endtask

  task automatic expect_val(input logic [2:0] a, input logic [31:0] e, input string r);
    @(negedge clk); #1; addr = a;
    #1; checks++;
    if (rdata !== e) begin
      errors++;
      $display("FAIL %s directed addr %0d actual %h expected %h", r, a, rdata, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1; rst_n = 1;
    for (int i = 0; i < 8; i++) expect_val(3'(i), 32'd0, "R9");
    // R3 load near carry and near wrap while stopped
    put(0, 32'hFFFF_FFF0); put(1, 32'h0);
    expect_val(0, 32'hFFFF_FFF0, "R3");
    put(2, 32'hFFFF_FFF1);
    expect_val(2, 32'h1, "R2");
    run(40, 0);
    expect_val(1, 32'h1, "R1");
    put(0, 32'h1234); // ignored while running
    run(5, 0);
    put(2, 0);
    put(0, 32'hFFFF_FFFE); put(1, 32'hFFFF_FFFF);
    put(2, 1);
    run(4, 0);
    expect_val(1, 32'h0, "R1");
    // R6/R8 comparator without auto-increment, then R5 clear
    put(2, 0); put(0, 0); put(1, 0);
    put(4, 32'd20); put(5, 0);
    put(2, 32'h7);
    run(30, 0);
    expect_val(3, 1, "R6");
    expect_val(4, 32'd20, "R8");
    put(3, 0);
    expect_val(3, 1, "R5");
    put(2, 32'h5);
    put(3, 1);
    expect_val(3, 0, "R5");
    // R7 periodic events
    put(6, 32'd7); put(4, 32'd200); put(2, 32'hF);
    run(120, 1);
    put(3, 1);
    run(60, 1);
    // R6 comparator below the count
    put(4, 32'd3);
    run(3, 0);
    expect_val(3, 1, "R6");
    // random phase
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk); #1;
      tick = 1'($urandom);
      addr = 3'($urandom_range(0, 7));
      wr = ($urandom_range(0, 9) == 0);
      case (addr)
        0, 4: wdata = m_cnt[31:0] + 32'($urandom_range(0, 300));
        1, 5: wdata = m_cnt[63:32];
        6: wdata = 32'($urandom_range(0, 40));
        default: wdata = $urandom;
      endcase
    end
    @(negedge clk); #1; wr = 0;
    run(10, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule